// File: doc/BRIEF.md
# Parallel Flash Bus Mode Controller

This block is the device-side front end of an asynchronous, byte-wide, NOR-style parallel flash. Every clock it samples the four active-low bus strobes (chip enable, output enable, write enable and a hardware reset pin), together with the address and the incoming data byte. From these it works out the current bus mode: read, write, output disabled, standby or reset. It also keeps an internal operating mode, which is one of read-array, identification (autoselect), program-armed or busy. That mode decides what is placed on the data bus. The bus carries array contents, a manufacturer or device code, operation status bits, or nothing at all.

Each recognised write cycle produces a one-cycle strobe on a command port carrying the sampled address and data. The same write also feeds a small command decoder. Byte `8'h90` enters identification mode. Byte `8'hF0` leaves it. Byte `8'hA0` arms a program, and the next write supplies the target address and data. Byte `8'h10` erases the whole array. The array itself is a small behavioural register file. Programs and erases take a parameterised number of clocks. A deselect does not stop them. A hardware reset pin held low long enough aborts them.

Top module: `flash_bus_front`

## Requirements
- R1: With chip enable low, output enable low and write enable high (sampled), the block drives `dout_en` high, and in read-array mode `dout` equals the array byte at the sampled address. The array powers up holding byte `(i*37+5) mod 256` at address i.
- R2: With chip enable low, write enable low and output enable high, the block raises `cmd_stb` for exactly one cycle, and `cmd_addr`/`cmd_data` carry the sampled address and data. When all three strobes are low, neither a read nor a write is recognised.
- R3: Whenever output enable is sampled high, `dout_en` is low.
- R4: Whenever chip enable is sampled high, `dout_en` and `cmd_stb` are both low.
- R5: After power-on reset the mode is read-array, so reads return array contents with no command written first.
- R6: After a write of `8'h90` in read-array mode, reads return `MFR_CODE` at address 0, `DEV_CODE` at address 1 and `8'h00` at any other address.
- R7: In identification mode, a write of `8'hF0` returns the mode to read-array.
- R8: A write of `8'hA0` followed by a write of address A and data D makes the block busy for `PROG_CYCLES` clocks. After that, reads at A return D.
- R9: While busy, reads return status: bit 7 is the inverse of bit 7 of the byte being written (`8'hFF` for an erase), bit 6 flips between successive read cycles, and bits 5..0 are zero.
- R10: Holding chip enable high during a busy operation does not stop it, and the operation still completes.
- R11: When the reset pin is sampled low on `RST_MIN` consecutive clocks, any program or erase is abandoned with the array unchanged, and the mode returns to read-array, from identification mode too.
- R12: While the reset pin is sampled low, `dout_en` and `cmd_stb` stay low and writes have no effect on the mode.
- R13: A reset pulse sampled low on fewer than `RST_MIN` clocks does not abort a busy operation.
- R14: A write of `8'h10` in read-array mode is busy for `ERASE_CYCLES` clocks and then leaves every array byte at `8'hFF`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Active-low power-on reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| hw_rst_n | input | 1 | Active-low hardware reset pin, filtered by `RST_MIN` |
| addr | input | AW | Byte address |
| din | input | 8 | Data byte written by the host |
| dout | output | 8 | Data byte driven toward the host |
| dout_en | output | 1 | Output driver enable; low means high impedance |
| cmd_stb | output | 1 | One-cycle strobe for each recognised write cycle |
| cmd_addr | output | AW | Address sampled with the write |
| cmd_data | output | 8 | Data sampled with the write |

## Verification
Every combination of the three bus strobes is applied, so that read, write, output-disabled, standby and the all-low conflict can each be told apart at `dout_en` and `cmd_stb`. The same address is read under each internal mode: read-array, identification, busy-program and busy-erase. This shows that the data source follows the mode and not the strobes. Two reset pulses are placed inside a busy program, one a sample short of `RST_MIN` and one longer. Together they separate an ignored glitch from a real abort, and a follow-up read shows whether the target byte was written. Further cases cover a deselect held through a whole program and a command written while reset is low, each read back through the normal read path.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

   typedef enum logic [1:0] {
      MD_READ  = 2'd0,
      MD_AUTO  = 2'd1,
      MD_ARMED = 2'd2,
      MD_BUSY  = 2'd3
   } mode_e;

   localparam int unsigned DW = 8;

   localparam logic [DW-1:0] CMD_AUTOSEL = 8'h90;
   localparam logic [DW-1:0] CMD_EXIT    = 8'hF0;
   localparam logic [DW-1:0] CMD_PROG    = 8'hA0;
   localparam logic [DW-1:0] CMD_ERASE   = 8'h10;

   // Power-up content of array word i
   function automatic logic [DW-1:0] init_byte(int unsigned i);
      return DW'((i * 37 + 5) % 256);
   endfunction

endpackage

// File: rtl/fbf_bus_sample.sv
module fbf_bus_sample
   import fbf_pkg::*;
#(
   parameter int unsigned AW          = 4,
   parameter int unsigned RST_MIN     = 4,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          hw_rst_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic [AW-1:0] s_addr,
   output logic [DW-1:0] s_din,
   output logic          rd,
   output logic          rd_start,
   output logic          wr_stb,
   output logic          abort
);

   localparam int unsigned BW  = 4 + AW + DW;
   localparam int unsigned RCW = $clog2(RST_MIN + 1);
   localparam logic [BW-1:0] IDLE_VAL = {4'b1111, {(AW + DW){1'b0}}};

   generate
      if (RST_MIN < 1) begin : g_bad_rst
         $error("RST_MIN must be at least 1");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_sync
         $error("SYNC_STAGES must be 1 or 2");
      end
   endgenerate

   logic [BW-1:0] raw;
   logic [BW-1:0] stage [SYNC_STAGES];
   logic [BW-1:0] smp;

   assign raw = {ce_n, oe_n, we_n, hw_rst_n, addr, din};

   genvar k;
   generate
      for (k = 0; k < SYNC_STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) stage[k] <= IDLE_VAL;
               else        stage[k] <= raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) stage[k] <= IDLE_VAL;
               else        stage[k] <= stage[k-1];
            end
         end
      end
   endgenerate

   assign smp = stage[SYNC_STAGES-1];

   logic s_ce_n, s_oe_n, s_we_n, s_rst_n;
   assign {s_ce_n, s_oe_n, s_we_n, s_rst_n, s_addr, s_din} = smp;

   logic hold, wr, rd_q, wr_q;
   logic [RCW-1:0] rcnt;

   assign hold = !s_rst_n;
   assign rd   = !hold && !s_ce_n && !s_oe_n &&  s_we_n;
   assign wr   = !hold && !s_ce_n && !s_we_n &&  s_oe_n;

   assign rd_start = rd && !rd_q;
   assign wr_stb   = wr && !wr_q;
   assign abort    = hold && (rcnt == RCW'(RST_MIN - 1));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
         rcnt <= '0;
      end else begin
         rd_q <= rd;
         wr_q <= wr;
         if (!hold)                     rcnt <= '0;
         else if (rcnt < RCW'(RST_MIN)) rcnt <= rcnt + 1'b1;
      end
   end

   // R2: a held write cycle produces a single strobe
   p_stb_single_r2: assert property (@(posedge clk) disable iff (!por_n)
      wr_stb |=> !wr_stb);

endmodule

// File: rtl/fbf_mode_ctrl.sv
module fbf_mode_ctrl
   import fbf_pkg::*;
#(
   parameter int unsigned AW           = 4,
   parameter int unsigned PROG_CYCLES  = 40,
   parameter int unsigned ERASE_CYCLES = 100
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          wr_stb,
   input  logic          rd_start,
   input  logic          abort,
   input  logic [AW-1:0] s_addr,
   input  logic [DW-1:0] s_din,
   output mode_e         mode,
   output logic          arr_we,
   output logic          arr_erase,
   output logic [AW-1:0] arr_waddr,
   output logic [DW-1:0] arr_wdata,
   output logic          poll_bit,
   output logic          tog
);

   localparam int unsigned CMAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int unsigned CW   = $clog2(CMAX + 1);

   generate
      if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_cycles
         $error("busy durations must be at least one clock");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          is_erase;
   logic          last;

   assign last      = (mode == MD_BUSY) && (cnt == CW'(1)) && !abort;
   assign arr_we    = last && !is_erase;
   assign arr_erase = last &&  is_erase;
   assign poll_bit  = ~arr_wdata[DW-1];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode      <= MD_READ;
         cnt       <= '0;
         is_erase  <= 1'b0;
         arr_waddr <= '0;
         arr_wdata <= '0;
      end else if (abort) begin
         mode <= MD_READ;
         cnt  <= '0;
      end else begin
         unique case (mode)
            MD_READ: if (wr_stb) begin
               if (s_din == CMD_AUTOSEL) mode <= MD_AUTO;
               else if (s_din == CMD_PROG) mode <= MD_ARMED;
               else if (s_din == CMD_ERASE) begin
                  mode      <= MD_BUSY;
                  is_erase  <= 1'b1;
                  arr_wdata <= '1;
                  cnt       <= CW'(ERASE_CYCLES);
               end
            end
            MD_AUTO: if (wr_stb && s_din == CMD_EXIT) mode <= MD_READ;
            MD_ARMED: if (wr_stb) begin
               mode      <= MD_BUSY;
               is_erase  <= 1'b0;
               arr_waddr <= s_addr;
               arr_wdata <= s_din;
               cnt       <= CW'(PROG_CYCLES);
            end
            MD_BUSY: begin
               cnt <= cnt - 1'b1;
               if (cnt == CW'(1)) mode <= MD_READ;
            end
            default: mode <= MD_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                           tog <= 1'b0;
      else if (rd_start && mode == MD_BUSY) tog <= ~tog;
   end

   // R11: a qualified reset always lands in read-array mode
   p_abort_read_r11: assert property (@(posedge clk) disable iff (!por_n)
      abort |=> (mode == MD_READ));

endmodule

// File: rtl/fbf_array.sv
module fbf_array
   import fbf_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          we,
   input  logic          erase,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 10) begin : g_bad_aw
         $error("AW must be between 1 and 10");
      end
   endgenerate

   logic [DW-1:0] words [DEPTH];

   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_word
         logic [DW-1:0] word_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                        word_q <= init_byte(i);
            else if (erase)                    word_q <= '1;
            else if (we && waddr == AW'(i))    word_q <= wdata;
         end
         assign words[i] = word_q;

         // R14: an erase pulse leaves this word all ones
         p_erase_fill_r14: assert property (@(posedge clk) disable iff (!por_n)
            erase |=> (word_q == '1));
      end
   endgenerate

   assign rdata = words[raddr];

endmodule

// File: rtl/fbf_out_mux.sv
module fbf_out_mux
   import fbf_pkg::*;
#(
   parameter int unsigned   AW       = 4,
   parameter logic [DW-1:0] MFR_CODE = 8'h37,
   parameter logic [DW-1:0] DEV_CODE = 8'hA1
) (
   input  logic          rd,
   input  mode_e         mode,
   input  logic [AW-1:0] s_addr,
   input  logic [DW-1:0] arr_rdata,
   input  logic          poll_bit,
   input  logic          tog,
   output logic [DW-1:0] dout,
   output logic          dout_en
);

   logic [DW-1:0] id_byte;
   logic [DW-1:0] status;

   always_comb begin
      if (s_addr == AW'(0))      id_byte = MFR_CODE;
      else if (s_addr == AW'(1)) id_byte = DEV_CODE;
      else                       id_byte = '0;
   end

   assign status  = {poll_bit, tog, {(DW - 2){1'b0}}};
   assign dout_en = rd;

   always_comb begin
      unique case (mode)
         MD_AUTO: dout = id_byte;
         MD_BUSY: dout = status;
         default: dout = arr_rdata;
      endcase
   end

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
   import fbf_pkg::*;
#(
   parameter int unsigned   AW           = 4,
   parameter int unsigned   RST_MIN      = 4,
   parameter int unsigned   SYNC_STAGES  = 1,
   parameter int unsigned   PROG_CYCLES  = 40,
   parameter int unsigned   ERASE_CYCLES = 100,
   parameter logic [7:0]    MFR_CODE     = 8'h37,
   parameter logic [7:0]    DEV_CODE     = 8'hA1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          hw_rst_n,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    din,
   output logic [7:0]    dout,
   output logic          dout_en,
   output logic          cmd_stb,
   output logic [AW-1:0] cmd_addr,
   output logic [7:0]    cmd_data
);

   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_din;
   logic          rd, rd_start, wr_stb, abort;
   mode_e         mode;
   logic          arr_we, arr_erase, poll_bit, tog;
   logic [AW-1:0] arr_waddr;
   logic [DW-1:0] arr_wdata, arr_rdata;

   fbf_bus_sample #(.AW(AW), .RST_MIN(RST_MIN), .SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .hw_rst_n(hw_rst_n), .addr(addr), .din(din),
      .s_addr(s_addr), .s_din(s_din), .rd(rd), .rd_start(rd_start),
      .wr_stb(wr_stb), .abort(abort)
   );

   fbf_mode_ctrl #(.AW(AW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_mode (
      .clk(clk), .por_n(por_n), .wr_stb(wr_stb), .rd_start(rd_start), .abort(abort),
      .s_addr(s_addr), .s_din(s_din), .mode(mode), .arr_we(arr_we),
      .arr_erase(arr_erase), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
      .poll_bit(poll_bit), .tog(tog)
   );

   fbf_array #(.AW(AW)) u_arr (
      .clk(clk), .por_n(por_n), .we(arr_we), .erase(arr_erase),
      .waddr(arr_waddr), .wdata(arr_wdata), .raddr(s_addr), .rdata(arr_rdata)
   );

   fbf_out_mux #(.AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mux (
      .rd(rd), .mode(mode), .s_addr(s_addr), .arr_rdata(arr_rdata),
      .poll_bit(poll_bit), .tog(tog), .dout(dout), .dout_en(dout_en)
   );

   assign cmd_stb  = wr_stb;
   assign cmd_addr = s_addr;
   assign cmd_data = s_din;

   // R3: output enable high keeps the bus released
   p_oe_gate_r3: assert property (@(posedge clk) disable iff (!por_n)
      $past(oe_n, SYNC_STAGES) |-> !dout_en);

   // R4: standby drives nothing and issues no command
   p_ce_gate_r4: assert property (@(posedge clk) disable iff (!por_n)
      $past(ce_n, SYNC_STAGES) |-> (!dout_en && !cmd_stb));

   // R12: reset pin low blocks every access
   p_rst_quiet_r12: assert property (@(posedge clk) disable iff (!por_n)
      !$past(hw_rst_n, SYNC_STAGES) |-> (!dout_en && !cmd_stb));

endmodule

// File: tb/sim_flash_bus_front.sv
module sim_flash_bus_front;

   localparam int CLK_NS  = 10;
   localparam int AW      = 4;
   localparam int RST_MIN = 4;
   localparam int PROG    = 40;
   localparam int ERASE   = 100;
   localparam logic [7:0] MFR = 8'h37;
   localparam logic [7:0] DEV = 8'hA1;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hw_rst_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0] din = '0;
   logic [7:0] dout;
   logic dout_en, cmd_stb;
   logic [AW-1:0] cmd_addr;
   logic [7:0] cmd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   flash_bus_front #(.AW(AW), .RST_MIN(RST_MIN), .PROG_CYCLES(PROG),
                     .ERASE_CYCLES(ERASE), .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
      .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .hw_rst_n(hw_rst_n), .addr(addr), .din(din), .dout(dout),
      .dout_en(dout_en), .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
   );

   function automatic logic [7:0] pwr_byte(int i);
      return 8'((i * 37 + 5) % 256);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   // Drive strobes for one sample, return outputs seen after it
   task automatic cycle(logic c, logic o, logic w, logic [AW-1:0] a, logic [7:0] d,
                        output logic [7:0] q, output logic en, output logic stb);
      @(negedge clk);
      ce_n = c; oe_n = o; we_n = w; addr = a; din = d;
      @(negedge clk);
      q = dout; en = dout_en; stb = cmd_stb;
      idle();
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [7:0] q, output logic en);
      logic stb;
      cycle(1'b0, 1'b0, 1'b1, a, 8'h00, q, en, stb);
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      logic [7:0] q; logic en, stb;
      cycle(1'b0, 1'b1, 1'b0, a, d, q, en, stb);
      @(negedge clk);
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [7:0] q; logic en;
      @(negedge clk);
      check("R4 idle after reset dout_en", dout_en, 0);
      for (int i = 0; i < 16; i += 5) begin
         rd(AW'(i), q, en);
         check("R5 power-up read enable", en, 1);
         check("R5 power-up read data", q, pwr_byte(i));
      end
   endtask

   task automatic t_strobes();
      logic [7:0] q; logic en, stb;
      cycle(1'b0, 1'b0, 1'b1, 4'd9, 8'h00, q, en, stb);
      check("R1 read enable", en, 1);
      check("R1 read data", q, pwr_byte(9));
      cycle(1'b0, 1'b1, 1'b1, 4'd9, 8'h00, q, en, stb);
      check("R3 oe high dout_en", en, 0);
      cycle(1'b0, 1'b0, 1'b0, 4'd9, 8'h90, q, en, stb);
      check("R2 all low no read", en, 0);
      check("R2 all low no write", stb, 0);
      cycle(1'b1, 1'b0, 1'b1, 4'd9, 8'h00, q, en, stb);
      check("R4 ce high read dout_en", en, 0);
      cycle(1'b1, 1'b1, 1'b0, 4'd9, 8'h90, q, en, stb);
      check("R4 ce high write stb", stb, 0);
      cycle(1'b0, 1'b1, 1'b0, 4'd5, 8'h5A, q, en, stb);
      check("R2 write stb", stb, 1);
      check("R2 write addr", cmd_addr, 5);
      check("R2 write data", cmd_data, 8'h5A);
      check("R2 write no drive", en, 0);
      @(negedge clk);
      check("R2 stb one cycle", cmd_stb, 0);
      rd(4'd0, q, en);
      check("R2 ignored writes keep read-array", q, pwr_byte(0));
   endtask

   task automatic t_autosel();
      logic [7:0] q; logic en;
      wr(4'd0, 8'h90);
      rd(4'd0, q, en);
      check("R6 manufacturer code", q, MFR);
      rd(4'd1, q, en);
      check("R6 device code", q, DEV);
      rd(4'd7, q, en);
      check("R6 other id address", q, 8'h00);
      wr(4'd0, 8'hF0);
      rd(4'd0, q, en);
      check("R7 back to array", q, pwr_byte(0));
   endtask

   task automatic t_program();
      logic [7:0] q1, q2; logic en;
      wr(4'd0, 8'hA0);
      wr(4'd2, 8'h3C);
      rd(4'd2, q1, en);
      rd(4'd2, q2, en);
      check("R9 status bit7 inverse", q1[7], 1);
      check("R9 status low bits zero", q1[5:0], 0);
      check("R9 status bit6 toggles", q1[6] ^ q2[6], 1);
      wait_clk(PROG + 4);
      rd(4'd2, q1, en);
      check("R8 programmed byte", q1, 8'h3C);
   endtask

   task automatic t_deselect();
      logic [7:0] q; logic en;
      wr(4'd0, 8'hA0);
      wr(4'd6, 8'hC3);
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b0;
      wait_clk(PROG + 4);
      idle();
      rd(4'd6, q, en);
      check("R10 deselected program completes", q, 8'hC3);
   endtask

   task automatic t_short_reset();
      logic [7:0] q; logic en;
      wr(4'd0, 8'hA0);
      wr(4'd7, 8'h01);
      @(negedge clk);
      hw_rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = 4'd7;
      @(negedge clk);
      check("R12 read blocked during reset", dout_en, 0);
      idle();
      wait_clk(RST_MIN - 2);
      hw_rst_n = 1'b1;
      rd(4'd7, q, en);
      check("R13 short pulse keeps busy", q[7:6] == 2'b00 || q[5:0] != 0, 0);
      wait_clk(PROG + 4);
      rd(4'd7, q, en);
      check("R13 program finishes after short pulse", q, 8'h01);
   endtask

   task automatic t_abort();
      logic [7:0] q; logic en;
      wr(4'd0, 8'hA0);
      wr(4'd8, 8'h11);
      @(negedge clk);
      hw_rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; addr = 4'd9; din = 8'h90;
      @(negedge clk);
      check("R12 write blocked during reset", cmd_stb, 0);
      idle();
      wait_clk(RST_MIN + 1);
      hw_rst_n = 1'b1;
      rd(4'd8, q, en);
      check("R11 read enabled after abort", en, 1);
      check("R11 aborted byte unchanged", q, pwr_byte(8));
      wait_clk(PROG + 4);
      rd(4'd8, q, en);
      check("R11 aborted program never lands", q, pwr_byte(8));
      rd(4'd0, q, en);
      check("R12 command during reset ignored", q, pwr_byte(0));
      wr(4'd0, 8'h90);
      @(negedge clk);
      hw_rst_n = 1'b0;
      wait_clk(RST_MIN + 1);
      hw_rst_n = 1'b1;
      rd(4'd0, q, en);
      check("R11 reset leaves autoselect", q, pwr_byte(0));
   endtask

   task automatic t_erase();
      logic [7:0] q; logic en;
      wr(4'd0, 8'h10);
      rd(4'd0, q, en);
      check("R9 erase status bit7", q[7], 0);
      wait_clk(ERASE + 4);
      rd(4'd0, q, en);
      check("R14 erased first byte", q, 8'hFF);
      rd(4'd15, q, en);
      check("R14 erased last byte", q, 8'hFF);
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      wait_clk(3);
      por_n = 1'b1;
      t_reset_state();
      t_strobes();
      t_autosel();
      t_program();
      t_deselect();
      t_short_reset();
      t_abort();
      t_erase();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule